// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block decides which clock domains of a processor core may run. Four power states are walked through: Running, Stop-Grant, Sleep and Deep Sleep. Two asynchronous, active-low requests drive the walk. A stop-clock request parks the core in Stop-Grant. A sleep request, honoured only from Stop-Grant, shuts the bus and interrupt-controller clocks as well. Losing the bus clock while asleep sinks the block into Deep Sleep.

The block drives three clock-enable outputs, for the core, the system bus and the interrupt controller. It also drives an enable that lets snoops and interrupts be accepted, and a one-cycle acknowledge pulse when the core is parked. An over-temperature flag sets a latched thermal-trip output, which forces every enable low. That latch is cleared only by reset, and it is set again right after reset if the condition persists. Bus-clock presence and over-temperature arrive as synchronous inputs from external detectors. The actual gating cells, the PLL and supply removal are outside this block.

Top module: `lps_seq`

## Requirements
- R1: Leaving Running happens only on a stop-clock request. The move goes to Stop-Grant, and `grant_ack` is high for exactly one cycle, in the first cycle of Stop-Grant.
- R2: In Stop-Grant, `core_clk_en` is low, while `bus_clk_en`, `intc_clk_en` and `snoop_int_en` are high.
- R3: Releasing the stop-clock request in Stop-Grant returns to Running with all enables high. This move takes priority over a sleep request that becomes active on the same cycle.
- R4: A sleep request in Stop-Grant enters Sleep, where `core_clk_en`, `bus_clk_en`, `intc_clk_en` and `snoop_int_en` are all low.
- R5: Releasing the sleep request in Sleep returns to Stop-Grant with bus and interrupt-controller clocks enabled, and without an acknowledge pulse.
- R6: In Sleep, `bclk_present` low moves to Deep Sleep on the next edge, and in Deep Sleep `bclk_present` high moves back to Sleep. In both states a change of the stop-clock request has no effect.
- R7: While `rst_n` is low, the block is in Running with all enables high, `grant_ack` low and `therm_trip` low. `pwr_state` encodes Running=0, Stop-Grant=1, Sleep=2 and Deep Sleep=3.
- R8: A sleep request in Running is ignored: no state change and no acknowledge.
- R9: `overtemp` high sets `therm_trip` on the next edge. The latch holds after `overtemp` falls, and while it is set every clock enable, `snoop_int_en` and `grant_ack` are low.
- R10: If `overtemp` is still high when reset is released, `therm_trip` is set again on the first edge after release.
- R11: Each request pin passes `SYNC_STAGES` flops before use. A pin change is acted on at the (`SYNC_STAGES`+1)-th rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stpclk_req_n | input | 1 | Asynchronous stop-clock request, active low |
| sleep_req_n | input | 1 | Asynchronous sleep request, active low |
| bclk_present | input | 1 | Synchronous bus-clock-present flag |
| overtemp | input | 1 | Synchronous over-temperature flag |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | System bus clock enable |
| intc_clk_en | output | 1 | Interrupt-controller clock enable |
| snoop_int_en | output | 1 | Snoops and interrupts may be accepted |
| grant_ack | output | 1 | One-cycle Stop-Grant acknowledge |
| therm_trip | output | 1 | Latched thermal trip |
| pwr_state | output | 2 | Current power state code |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. This makes the request latency exactly three edges, and that value is probed one edge early and on the edge itself. With that depth fixed, the whole state graph can be reached in a few dozen cycles. The walk covers Deep Sleep entry and exit, the priority of a released stop-clock over a new sleep request, and a thermal trip both raised in operation and held across reset release.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_STOPG = 2'd1,
        PS_SLEEP = 2'd2,
        PS_DEEP  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       ack;
    } seq_regs_t;

    typedef struct packed {
        logic core;
        logic bus;
        logic intc;
        logic snoop;
    } clk_en_t;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stp_req,
    input  logic       slp_req,
    input  logic       bclk_ok,
    output pwr_state_e state_o,
    output logic       ack_o
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.state)
            PS_RUN: begin
                if (stp_req) begin
                    r_d.state = PS_STOPG;
                    r_d.ack   = 1'b1;
                end
            end
            PS_STOPG: begin
                if (!stp_req)     r_d.state = PS_RUN;
                else if (slp_req) r_d.state = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (!bclk_ok)      r_d.state = PS_DEEP;
                else if (!slp_req) r_d.state = PS_STOPG;
            end
            PS_DEEP: begin
                if (bclk_ok) r_d.state = PS_SLEEP;
            end
            default: r_d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PS_RUN, ack: 1'b0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign ack_o   = r_q.ack;

    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |=> !r_q.ack);
    p_ack_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |-> (r_q.state == PS_STOPG && $past(r_q.state) == PS_RUN));
    p_run_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RUN && $past(r_q.state) == PS_STOPG) |-> !$past(stp_req));
    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_SLEEP && $past(r_q.state) != PS_SLEEP)
            |-> ($past(r_q.state) == PS_STOPG || $past(r_q.state) == PS_DEEP));
    p_deep_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_DEEP && $past(r_q.state) != PS_DEEP)
            |-> ($past(r_q.state) == PS_SLEEP && !$past(bclk_ok)));
endmodule

// File: rtl/lps_thermal.sv
module lps_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic overtemp,
    output logic trip_o
);
    logic trip_d, trip_q;

    always_comb begin
        trip_d = trip_q | overtemp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_d;
    end

    assign trip_o = trip_q;

    p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q |=> trip_q);
    p_trip_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |=> trip_q);
endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stpclk_req_n,
    input  logic       sleep_req_n,
    input  logic       bclk_present,
    input  logic       overtemp,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       intc_clk_en,
    output logic       snoop_int_en,
    output logic       grant_ack,
    output logic       therm_trip,
    output logic [1:0] pwr_state
);
    localparam int REQ_N = 2;

    logic [REQ_N-1:0] pin_n, synced_n;
    pwr_state_e       state;
    logic             ack, trip;
    clk_en_t          en_raw, en_out;

    assign pin_n = {sleep_req_n, stpclk_req_n};

    for (genvar gi = 0; gi < REQ_N; gi++) begin : g_sync
        lps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(pin_n[gi]),
            .sync_o (synced_n[gi])
        );
    end

    lps_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stp_req(~synced_n[0]),
        .slp_req(~synced_n[1]),
        .bclk_ok(bclk_present),
        .state_o(state),
        .ack_o  (ack)
    );

    lps_thermal u_thermal (
        .clk     (clk),
        .rst_n   (rst_n),
        .overtemp(overtemp),
        .trip_o  (trip)
    );

    always_comb begin
        unique case (state)
            PS_RUN:   en_raw = '{core: 1'b1, bus: 1'b1, intc: 1'b1, snoop: 1'b1};
            PS_STOPG: en_raw = '{core: 1'b0, bus: 1'b1, intc: 1'b1, snoop: 1'b1};
            default:  en_raw = '{core: 1'b0, bus: 1'b0, intc: 1'b0, snoop: 1'b0};
        endcase
        en_out = trip ? '0 : en_raw;
    end

    assign core_clk_en  = en_out.core;
    assign bus_clk_en   = en_out.bus;
    assign intc_clk_en  = en_out.intc;
    assign snoop_int_en = en_out.snoop;
    assign grant_ack    = ack & ~trip;
    assign therm_trip   = trip;
    assign pwr_state    = state;

    p_trip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        therm_trip |-> !(core_clk_en || bus_clk_en || intc_clk_en || grant_ack));
    p_bus_stopg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && !therm_trip) |-> (bus_clk_en && !core_clk_en));
endmodule

// File: tb/lps_seq_bench.sv
`timescale 1ns/1ps
module lps_seq_bench;
    logic clk = 1'b0;
    logic rst_n, stpclk_req_n, sleep_req_n, bclk_present, overtemp;
    logic core_clk_en, bus_clk_en, intc_clk_en, snoop_int_en, grant_ack, therm_trip;
    logic [1:0] pwr_state;

    always #5 clk = ~clk;

    lps_seq u_lps_seq (
        .clk(clk), .rst_n(rst_n), .stpclk_req_n(stpclk_req_n),
        .sleep_req_n(sleep_req_n), .bclk_present(bclk_present),
        .overtemp(overtemp), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
        .intc_clk_en(intc_clk_en), .snoop_int_en(snoop_int_en),
        .grant_ack(grant_ack), .therm_trip(therm_trip), .pwr_state(pwr_state)
    );

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_err = 0;
    bit done  = 0;

    // {state[1:0], core, bus, intc, snoop, trip, ack}
    function automatic logic [7:0] mk(logic [1:0] s, logic c, logic b, logic i,
                                      logic sn, logic t, logic a);
        return {s, c, b, i, sn, t, a};
    endfunction

    localparam logic [7:0] E_RUN   = 8'b00_1111_0_0;
    localparam logic [7:0] E_STOPG = 8'b01_0111_0_0;
    localparam logic [7:0] E_SLEEP = 8'b10_0000_0_0;
    localparam logic [7:0] E_DEEP  = 8'b11_0000_0_0;

    task automatic expect_out(string tag, logic [7:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        q.push_back(it);
        #3;
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: compares queued expectations against outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] obs;
                it  = q.pop_front();
                obs = {pwr_state, core_clk_en, bus_clk_en, intc_clk_en,
                       snoop_int_en, therm_trip, grant_ack};
                n_vec++;
                if (obs !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: got %b expected %b", it.tag, obs, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stpclk_req_n = 1'b1; sleep_req_n = 1'b1;
        bclk_present = 1'b1; overtemp = 1'b0;
        cyc(2);
        expect_out("R7 reset state", E_RUN);
        rst_n = 1'b1;
        cyc(1);
        expect_out("R7 after release", E_RUN);

        // R8: sleep in Running ignored
        sleep_req_n = 1'b0;
        cyc(3);
        expect_out("R8 sleep ignored", E_RUN);
        cyc(3);
        expect_out("R8 still running", E_RUN);
        sleep_req_n = 1'b1;
        cyc(4);

        // R11 latency and R1 ack
        stpclk_req_n = 1'b0;
        cyc(2);
        expect_out("R11 not yet acted", E_RUN);
        cyc(1);
        expect_out("R1 enter stop-grant with ack", mk(2'd1, 0, 1, 1, 1, 0, 1));
        cyc(1);
        expect_out("R1 ack single cycle / R2 enables", E_STOPG);

        // R4 sleep
        sleep_req_n = 1'b0;
        cyc(3);
        expect_out("R4 enter sleep", E_SLEEP);

        // R6 stop-clock release ignored in Sleep
        stpclk_req_n = 1'b1;
        cyc(4);
        expect_out("R6 stop release ignored in sleep", E_SLEEP);
        stpclk_req_n = 1'b0;
        cyc(3);

        // R6 deep sleep
        bclk_present = 1'b0;
        cyc(1);
        expect_out("R6 enter deep sleep", E_DEEP);
        sleep_req_n = 1'b1;
        cyc(3);
        expect_out("R6 deep holds", E_DEEP);
        sleep_req_n = 1'b0;
        cyc(3);
        bclk_present = 1'b1;
        cyc(1);
        expect_out("R6 back to sleep", E_SLEEP);

        // R5 leave sleep
        sleep_req_n = 1'b1;
        cyc(3);
        expect_out("R5 back to stop-grant no ack", E_STOPG);
        cyc(1);
        expect_out("R5 stays stop-grant", E_STOPG);

        // R3 priority: release stop and request sleep together
        stpclk_req_n = 1'b1;
        sleep_req_n  = 1'b0;
        cyc(3);
        expect_out("R3 run wins over sleep", E_RUN);
        cyc(2);
        expect_out("R3 R8 stays running", E_RUN);
        sleep_req_n = 1'b1;
        cyc(3);

        // R9 thermal trip
        overtemp = 1'b1;
        cyc(1);
        expect_out("R9 trip set", mk(2'd0, 0, 0, 0, 0, 1, 0));
        overtemp = 1'b0;
        cyc(3);
        expect_out("R9 trip latched", mk(2'd0, 0, 0, 0, 0, 1, 0));
        stpclk_req_n = 1'b0;
        cyc(3);
        expect_out("R9 ack masked by trip", mk(2'd1, 0, 0, 0, 0, 1, 0));
        stpclk_req_n = 1'b1;
        cyc(3);
        rst_n = 1'b0;
        cyc(1);
        expect_out("R7 reset clears trip", E_RUN);

        // R10 overtemp across reset release
        overtemp = 1'b1;
        cyc(2);
        expect_out("R10 held clear in reset", E_RUN);
        rst_n = 1'b1;
        cyc(1);
        expect_out("R10 trip re-set after release", mk(2'd0, 0, 0, 0, 0, 1, 0));
        overtemp = 1'b0;
        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        cyc(2);
        expect_out("R10 cleared with no overtemp", E_RUN);

        cyc(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule